// File: doc/BRIEF.md
# Input Port Head-of-Line Request Stage

This block sits on the input side of a time-slotted cell switch whose fabric is set up by request and acknowledge before any cell data moves. Arriving cells are written into a first-in first-out buffer. When the slot timer marks the start of a slot, the block shifts a short request word into the fabric. The word carries a presence flag, an optional priority field and the destination port number of the oldest buffered cell. It then waits for a one-bit grant strobe from the fabric.

On a positive grant, the block shifts out the body of that oldest cell. The destination number is not part of this stream, because the path is already set. The cell leaves the buffer only after its last body bit has gone. On a refusal, the cell stays at the head and is offered again in the next slot, as often as needed. The buffer never loses an admitted cell. The only loss point is an arrival that finds the buffer full, and a saturating counter tallies such arrivals.

Top module: `hol_req_port`

## Requirements
- R1: After a synchronous active-low reset, `req_vld` and `tx_vld` are 0, `drop_cnt` is 0 and the buffer is empty.
- R2: A `slot_start` pulse seen while the block is idle starts a request. From the next cycle, `req_vld` is high for exactly 1+P+A cycles, where A = log2(N_PORTS) and P = PRIO_W when PRIO_EN=1 (else 0). During those cycles `req_bit` carries, first bit first: the presence flag, then the priority field MSB first, then the destination MSB first.
- R3: If the buffer is empty when the slot starts, the request is still sent, with every bit (presence flag included) equal to 0.
- R4: While waiting after a request for a present cell, a grant strobe (`ack_stb`=1 with `ack_bit`=1) makes `tx_vld` high for exactly BODY_W cycles starting the next cycle. `tx_bit` gives the head cell's body MSB first, with no destination bits.
- R5: A strobe with `ack_bit`=0 returns the block to idle with the head cell kept. The next request carries the same cell.
- R6: Cells are requested and sent in arrival order.
- R7: An arrival that finds DEPTH cells stored is dropped and `drop_cnt` rises by one, saturating at its maximum. An arrival in the same cycle as the final body bit of a transmission is accepted, because that cell's slot is freed in that cycle.
- R8: `slot_start` outside idle is ignored, `ack_stb` outside the waiting state is ignored, and a grant to a request whose presence flag was 0 sends nothing.
- R9: The head cell is removed only at the end of its transmission, so a request made before then names it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_vld | input | 1 | An arriving cell is present this cycle |
| cell_dest | input | ADDR_W | Destination port of the arriving cell |
| cell_prio | input | PRIO_W | Priority of the arriving cell |
| cell_body | input | BODY_W | Body of the arriving cell |
| slot_start | input | 1 | Start-of-slot pulse |
| ack_stb | input | 1 | Fabric grant strobe |
| ack_bit | input | 1 | Grant value (1 = admitted) |
| req_vld | output | 1 | Request bit valid |
| req_bit | output | 1 | Serial request bit |
| tx_vld | output | 1 | Body bit valid |
| tx_bit | output | 1 | Serial body bit |
| drop_cnt | output | DROP_W | Saturating count of dropped arrivals |

## Verification
Two functions can meet in one cycle: the removal of the head cell on the last body bit, and a new arrival while the buffer is full. The bench provokes this by filling the buffer, granting the head cell and holding `cell_vld` high for the whole transmission. Every arrival before the last body cycle must be counted as dropped, and the arrival in the last body cycle must be stored. The later requests and bodies prove that it was stored, in order. A behavioural queue model compares both serial streams and the drop count on every cycle, also during a random phase where slot pulses and strobes fall in every state.

// File: rtl/hol_pkg.sv
// Shared types for the head-of-line request stage.
// Assumes: nothing beyond the enum encoding being private to the block.
package hol_pkg;

    // Slot phase of the input port.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a slot start
        ST_REQ  = 2'd1,   // shifting the request word
        ST_WAIT = 2'd2,   // waiting for the grant strobe
        ST_XMIT = 2'd3    // shifting the cell body
    } slot_st_t;

endpackage

// File: rtl/hol_fifo.sv
// Cell store for the input port: first in, first out, DEPTH entries.
// Refuses a write when full, except in a cycle that also removes an entry
// (R7). Assumes: pop is only raised while an entry is stored.
module hol_fifo #(
    parameter int DEPTH   = 4,
    parameter int ENTRY_W = 21
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               pop,
    output logic [ENTRY_W-1:0] head,
    output logic               not_empty,
    output logic               refused
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   level;
    logic               accept;

    // Room exists if not full or if the head leaves this cycle.
    always_comb begin
        accept  = wr_req && ((level != CNT_FULL) || pop);
        refused = wr_req && !accept;
    end

    // Storage write; data needs no reset.
    always_ff @(posedge clk) begin
        if (accept) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({accept, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    // Head view and presence flag.
    always_comb begin
        head      = mem[rd_ptr];
        not_empty = (level != '0);
    end

endmodule

// File: rtl/hol_piso.sv
// Parallel-load, shift-left register giving its MSB as a serial stream.
// Assumes: load and shift are never raised together.
module hol_piso #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    // Load a word or move it one bit toward the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/hol_slot_ctrl.sv
// Slot sequencer: idle -> request -> wait for grant -> body -> idle.
// Latches whether the request named a cell, so a grant to an empty request
// sends nothing (R8). Removes the head only after the last body bit (R9).
// Assumes: REQ_LEN >= 2 and BODY_W >= 2.
module hol_slot_ctrl
    import hol_pkg::*;
#(
    parameter int REQ_LEN = 6,
    parameter int BODY_W  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_start,
    input  logic ack_stb,
    input  logic ack_bit,
    input  logic hol_present,
    output logic req_load,
    output logic req_shift,
    output logic tx_load,
    output logic tx_shift,
    output logic pop,
    output logic req_vld,
    output logic tx_vld
);
    localparam int MAXL = (REQ_LEN > BODY_W) ? REQ_LEN : BODY_W;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [CW-1:0] REQ_LAST = CW'(REQ_LEN - 1);
    localparam logic [CW-1:0] TX_LAST  = CW'(BODY_W - 1);

    slot_st_t        st;
    logic [CW-1:0]   cnt;
    logic            act_q;

    // Control strobes decoded from the current phase.
    always_comb begin
        req_load  = (st == ST_IDLE) && slot_start;
        req_shift = (st == ST_REQ);
        tx_load   = (st == ST_WAIT) && ack_stb && ack_bit && act_q;
        tx_shift  = (st == ST_XMIT);
        pop       = (st == ST_XMIT) && (cnt == TX_LAST);
        req_vld   = (st == ST_REQ);
        tx_vld    = (st == ST_XMIT);
    end

    // Phase, bit counter and presence latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            act_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (slot_start) begin
                        st    <= ST_REQ;
                        cnt   <= '0;
                        act_q <= hol_present;
                    end
                end
                ST_REQ: begin
                    if (cnt == REQ_LAST) begin
                        st  <= ST_WAIT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (ack_stb) begin
                        st  <= (ack_bit && act_q) ? ST_XMIT : ST_IDLE;
                        cnt <= '0;
                    end
                end
                default: begin
                    if (cnt == TX_LAST) begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/hol_drop_ctr.sv
// Saturating event counter for refused arrivals (R7).
// Assumes: at most one event per cycle.
module hol_drop_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count up, holding at all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/hol_req_port.sv
// Input port of a request/grant slotted switch. Buffers arriving cells,
// sends a serial request for the oldest cell at each slot start, and on a
// grant sends that cell's body serially without its destination field.
// Assumes: slot timing and grant strobes come from the fabric; the
// fabric strobes a grant only after the request has been sent.
module hol_req_port #(
    parameter int N_PORTS = 8,
    parameter int ADDR_W  = $clog2(N_PORTS),
    parameter int PRIO_EN = 1,
    parameter int PRIO_W  = 2,
    parameter int BODY_W  = 16,
    parameter int DEPTH   = 4,
    parameter int DROP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cell_vld,
    input  logic [ADDR_W-1:0] cell_dest,
    input  logic [PRIO_W-1:0] cell_prio,
    input  logic [BODY_W-1:0] cell_body,
    input  logic              slot_start,
    input  logic              ack_stb,
    input  logic              ack_bit,
    output logic              req_vld,
    output logic              req_bit,
    output logic              tx_vld,
    output logic              tx_bit,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int HDR_W   = (PRIO_EN != 0) ? (PRIO_W + ADDR_W) : ADDR_W;
    localparam int REQ_LEN = 1 + HDR_W;
    localparam int ENTRY_W = PRIO_W + ADDR_W + BODY_W;

    logic [ENTRY_W-1:0] head;
    logic               hol_present, refused, pop;
    logic               req_load, req_shift, tx_load, tx_shift;
    logic               req_msb, tx_msb;
    logic [REQ_LEN-1:0] req_word;
    logic [HDR_W-1:0]   hdr;

    // Cell store (R6, R7).
    hol_fifo #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) fifo_i (
        .clk(clk), .rst_n(rst_n),
        .wr_req(cell_vld), .wr_data({cell_prio, cell_dest, cell_body}),
        .pop(pop), .head(head), .not_empty(hol_present), .refused(refused)
    );

    // Slot sequencing (R2, R4, R5, R8, R9).
    hol_slot_ctrl #(.REQ_LEN(REQ_LEN), .BODY_W(BODY_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .slot_start(slot_start), .ack_stb(ack_stb), .ack_bit(ack_bit),
        .hol_present(hol_present),
        .req_load(req_load), .req_shift(req_shift),
        .tx_load(tx_load), .tx_shift(tx_shift), .pop(pop),
        .req_vld(req_vld), .tx_vld(tx_vld)
    );

    // Request header: priority is carried only when enabled.
    generate
        if (PRIO_EN != 0) begin : g_prio_hdr
            assign hdr = {head[ENTRY_W-1 -: PRIO_W], head[BODY_W +: ADDR_W]};
        end else begin : g_plain_hdr
            assign hdr = head[BODY_W +: ADDR_W];
        end
    endgenerate

    // Request word; all zero when no cell is stored (R3).
    always_comb begin
        req_word = hol_present ? {1'b1, hdr} : '0;
    end

    // Request serialiser.
    hol_piso #(.W(REQ_LEN)) req_sh_i (
        .clk(clk), .rst_n(rst_n), .load(req_load), .load_val(req_word),
        .shift(req_shift), .msb(req_msb)
    );

    // Body serialiser; destination is not loaded (R4).
    hol_piso #(.W(BODY_W)) tx_sh_i (
        .clk(clk), .rst_n(rst_n), .load(tx_load), .load_val(head[BODY_W-1:0]),
        .shift(tx_shift), .msb(tx_msb)
    );

    // Lost-arrival tally (R7).
    hol_drop_ctr #(.W(DROP_W)) drop_i (
        .clk(clk), .rst_n(rst_n), .inc(refused), .count(drop_cnt)
    );

    // Serial outputs are quiet outside their phases.
    always_comb begin
        req_bit = req_vld && req_msb;
        tx_bit  = tx_vld && tx_msb;
    end

endmodule

// File: rtl/hol_req_port_chk.sv
// Protocol checker for hol_req_port, bound to every instance.
module hol_req_port_chk #(
    parameter int REQ_LEN = 6,
    parameter int BODY_W  = 16,
    parameter int DROP_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cell_vld,
    input logic              ack_stb,
    input logic              ack_bit,
    input logic              req_vld,
    input logic              tx_vld,
    input logic [DROP_W-1:0] drop_cnt
);
    logic [15:0] req_run, tx_run;

    // Lengths of the current high runs of the two valid outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_run <= '0;
            tx_run  <= '0;
        end else begin
            req_run <= req_vld ? req_run + 1'b1 : '0;
            tx_run  <= tx_vld ? tx_run + 1'b1 : '0;
        end
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!req_vld && !tx_vld && drop_cnt == '0));

    a_r2_req_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_vld) |-> (req_run == 16'(REQ_LEN)));

    a_r4_body_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_vld) |-> (tx_run == 16'(BODY_W)));

    a_r4_body_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_vld) |-> $past(ack_stb && ack_bit));

    a_r8_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && tx_vld));

    a_r7_drop_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt == $past(drop_cnt)) || (drop_cnt == $past(drop_cnt) + 1'b1));

    a_r7_drop_needs_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> $past(cell_vld));

endmodule

bind hol_req_port hol_req_port_chk #(
    .REQ_LEN(REQ_LEN), .BODY_W(BODY_W), .DROP_W(DROP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .ack_stb(ack_stb),
    .ack_bit(ack_bit), .req_vld(req_vld), .tx_vld(tx_vld), .drop_cnt(drop_cnt)
);

// File: tb/hol_req_port_tb_top.sv
// Bench: behavioural queue model compared every cycle, plus directed checks.
module hol_req_port_tb_top;
    localparam int ADDR_W  = 3;
    localparam int PRIO_W  = 2;
    localparam int BODY_W  = 16;
    localparam int DEPTH   = 4;
    localparam int DROP_W  = 8;
    localparam int REQ_LEN = 1 + PRIO_W + ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_vld = 1'b0, slot_start = 1'b0, ack_stb = 1'b0, ack_bit = 1'b0;
    logic [ADDR_W-1:0] cell_dest = '0;
    logic [PRIO_W-1:0] cell_prio = '0;
    logic [BODY_W-1:0] cell_body = '0;
    logic req_vld, req_bit, tx_vld, tx_bit;
    logic [DROP_W-1:0] drop_cnt;

    always #10 clk = ~clk;

    hol_req_port #(.N_PORTS(8), .PRIO_EN(1), .PRIO_W(PRIO_W), .BODY_W(BODY_W),
                   .DEPTH(DEPTH), .DROP_W(DROP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cell_vld(cell_vld), .cell_dest(cell_dest),
        .cell_prio(cell_prio), .cell_body(cell_body), .slot_start(slot_start),
        .ack_stb(ack_stb), .ack_bit(ack_bit), .req_vld(req_vld), .req_bit(req_bit),
        .tx_vld(tx_vld), .tx_bit(tx_bit), .drop_cnt(drop_cnt)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    task automatic check(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    typedef struct { logic [ADDR_W-1:0] d; logic [PRIO_W-1:0] p; logic [BODY_W-1:0] b; } cell_t;
    cell_t mq[$];
    int mst = 0, mcnt = 0, mdrop = 0;
    logic mact = 0;
    logic [REQ_LEN-1:0] mword = '0;
    logic [BODY_W-1:0]  mbody = '0;

    always @(posedge clk) begin : model
        if (!rst_n) begin
            mq.delete(); mst = 0; mcnt = 0; mdrop = 0; mact = 0; mword = '0;
        end else begin
            case (mst)
                0: if (slot_start) begin
                       mact  = (mq.size() > 0);
                       mword = mact ? {1'b1, mq[0].p, mq[0].d} : '0;
                       mst = 1; mcnt = 0;
                   end
                1: if (mcnt == REQ_LEN - 1) begin mst = 2; mcnt = 0; end else mcnt++;
                2: if (ack_stb) begin
                       if (ack_bit && mact) begin mst = 3; mcnt = 0; mbody = mq[0].b; end
                       else mst = 0;
                   end
                default: if (mcnt == BODY_W - 1) begin
                             mst = 0; mcnt = 0; void'(mq.pop_front());
                         end else mcnt++;
            endcase
            if (cell_vld) begin
                if (mq.size() < DEPTH) mq.push_back('{cell_dest, cell_prio, cell_body});
                else if (mdrop < 255) mdrop++;
            end
        end
    end

    // ---------------- monitor and per-cycle compare ----------------
    logic [REQ_LEN-1:0] rq_acc = '0, last_req = '0;
    logic [BODY_W-1:0]  tx_acc = '0, last_tx = '0;
    int rq_n = 0, tx_n = 0, reqs_seen = 0, txs_seen = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_vld == (mst == 1), "R2 req_vld vs model", req_vld, mst == 1);
            if (mst == 1) check(req_bit == mword[REQ_LEN-1-mcnt], "R2 req_bit vs model", req_bit, mword[REQ_LEN-1-mcnt]);
            check(tx_vld == (mst == 3), "R4 tx_vld vs model", tx_vld, mst == 3);
            if (mst == 3) check(tx_bit == mbody[BODY_W-1-mcnt], "R4 tx_bit vs model", tx_bit, mbody[BODY_W-1-mcnt]);
            check(drop_cnt == mdrop, "R7 drop_cnt vs model", drop_cnt, mdrop);
        end
        if (req_vld) begin rq_acc = {rq_acc[REQ_LEN-2:0], req_bit}; rq_n++; end
        else if (rq_n != 0) begin last_req = rq_acc; reqs_seen++; rq_n = 0; end
        if (tx_vld) begin tx_acc = {tx_acc[BODY_W-2:0], tx_bit}; tx_n++; end
        else if (tx_n != 0) begin last_tx = tx_acc; txs_seen++; tx_n = 0; end
    end

    // ---------------- stimulus tasks ----------------
    task automatic push(input logic [ADDR_W-1:0] d, input logic [PRIO_W-1:0] p, input logic [BODY_W-1:0] b);
        @(negedge clk); cell_vld = 1; cell_dest = d; cell_prio = p; cell_body = b;
        @(negedge clk); cell_vld = 0;
    endtask

    task automatic do_slot();
        @(negedge clk); slot_start = 1;
        @(negedge clk); slot_start = 0;
        repeat (REQ_LEN) @(negedge clk);
        #1;
    endtask

    task automatic grant(input logic b);
        @(negedge clk); ack_stb = 1; ack_bit = b;
        @(negedge clk); ack_stb = 0;
        repeat (BODY_W) @(negedge clk);
        #1;
    endtask

    function automatic logic [REQ_LEN-1:0] rword(input logic [ADDR_W-1:0] d, input logic [PRIO_W-1:0] p);
        return {1'b1, p, d};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
    endtask

    // ---------------- directed scenario ----------------
    initial begin : main
        int r0, t0;
        do_reset();
        check(req_vld == 0 && tx_vld == 0, "R1 outputs idle after reset", {req_vld, tx_vld}, 0);
        check(drop_cnt == 0, "R1 drop_cnt after reset", drop_cnt, 0);

        // R3: empty buffer gives an all-zero request; R8: grant to it sends nothing.
        do_slot();
        check(last_req == '0, "R3 empty request word", last_req, 0);
        t0 = txs_seen;
        grant(1);
        check(txs_seen == t0, "R8 grant to empty request ignored", txs_seen, t0);

        // R2/R5/R4/R6/R9
        push(3'd5, 2'd2, 16'hA5C3);
        push(3'd2, 2'd1, 16'h1234);
        do_slot();
        check(last_req == rword(3'd5, 2'd2), "R2 request word of head cell", last_req, rword(3'd5, 2'd2));
        grant(0);
        do_slot();
        check(last_req == rword(3'd5, 2'd2), "R5 refused cell requested again", last_req, rword(3'd5, 2'd2));
        grant(1);
        check(last_tx == 16'hA5C3, "R4 body sent without destination", last_tx, 16'hA5C3);
        do_slot();
        check(last_req == rword(3'd2, 2'd1), "R6 second cell follows first", last_req, rword(3'd2, 2'd1));
        grant(1);
        check(last_tx == 16'h1234, "R4 second body", last_tx, 16'h1234);

        // R8: strobes during the request and a slot start while waiting are ignored.
        push(3'd7, 2'd3, 16'hC0DE);
        r0 = reqs_seen; t0 = txs_seen;
        @(negedge clk); slot_start = 1;
        @(negedge clk); slot_start = 0;
        @(negedge clk); ack_stb = 1; ack_bit = 1; slot_start = 1;
        @(negedge clk); ack_stb = 0; slot_start = 0;
        repeat (REQ_LEN) @(negedge clk);
        #1;
        check(reqs_seen == r0 + 1, "R8 one request despite extra slot start", reqs_seen, r0 + 1);
        check(txs_seen == t0, "R8 strobe during request ignored", txs_seen, t0);
        @(negedge clk); slot_start = 1;
        @(negedge clk); slot_start = 0;
        repeat (REQ_LEN + 2) @(negedge clk);
        #1;
        check(reqs_seen == r0 + 1, "R8 slot start while waiting ignored", reqs_seen, r0 + 1);
        grant(1);
        check(last_tx == 16'hC0DE, "R9 cell still held after ignored strobes", last_tx, 16'hC0DE);

        // R7: overflow, then arrivals during a transmission of a full buffer.
        for (int i = 0; i < DEPTH; i++) push(3'(i), 2'(i), 16'hD000 + 16'(i));
        push(3'd1, 2'd0, 16'hBAD0);
        push(3'd1, 2'd0, 16'hBAD1);
        #1;
        check(drop_cnt == 2, "R7 arrivals to full buffer dropped", drop_cnt, 2);
        do_slot();
        check(last_req == rword(3'd0, 2'd0), "R6 oldest of full buffer", last_req, rword(3'd0, 2'd0));
        @(negedge clk); ack_stb = 1; ack_bit = 1;
        @(negedge clk); ack_stb = 0; cell_vld = 1; cell_dest = 3'd6; cell_prio = 2'd1; cell_body = 16'hEEEE;
        repeat (BODY_W) @(negedge clk);
        cell_vld = 0;
        #1;
        check(drop_cnt == 2 + BODY_W - 1, "R7 only the arrival at pop accepted", drop_cnt, 2 + BODY_W - 1);
        for (int i = 1; i < DEPTH; i++) begin
            do_slot();
            grant(1);
            check(last_tx == 16'hD000 + 16'(i), "R6 arrival order kept", last_tx, 16'hD000 + 16'(i));
        end
        do_slot();
        check(last_req == rword(3'd6, 2'd1), "R7 arrival at pop stored", last_req, rword(3'd6, 2'd1));
        grant(1);
        check(last_tx == 16'hEEEE, "R7 arrival at pop body", last_tx, 16'hEEEE);

        // R7 saturation.
        @(negedge clk); cell_vld = 1; cell_body = 16'h5555;
        repeat (DEPTH + 260) @(negedge clk);
        cell_vld = 0;
        #1;
        check(drop_cnt == 8'hFF, "R7 drop counter saturates", drop_cnt, 8'hFF);

        // R1 again, then random traffic against the model.
        do_reset();
        check(drop_cnt == 0, "R1 reset clears drop count", drop_cnt, 0);
        void'($urandom(7));
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            cell_vld   = ($urandom % 10) < 4;
            cell_dest  = 3'($urandom);
            cell_prio  = 2'($urandom);
            cell_body  = 16'($urandom);
            slot_start = ($urandom % 5) == 0;
            ack_stb    = ($urandom % 5) == 0;
            ack_bit    = ($urandom % 10) < 6;
        end
        @(negedge clk);
        cell_vld = 0; slot_start = 0; ack_stb = 0;
        repeat (40) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule